// File: doc/BRIEF.md
# Nine-State Predictive Switching Selector

This block chooses, once per control period, the switching state of a single-phase five-level T-type inverter. It has six gate outputs. A one-cycle sample strobe captures the fixed-point measurements: the reference voltage, both DC-link capacitor voltages, the filter inductor current, the filter capacitor voltage and the load current. The block also captures the switching weight at the same time. It then steps through the nine candidate states, one per clock. For each candidate it predicts the next filter capacitor voltage with a forward-Euler model of the LC filter. The capacitor step uses the predicted inductor current, so each candidate's terminal voltage reaches the tracked quantity.

Each candidate's cost has three terms:
- the tracking error;
- a penalty on toggles of the four outer switches, relative to the state currently applied;
- a neutral-point imbalance term.

The imbalance term tells apart the redundant half-level states by their effect on the capacitor charge. The candidate with the lowest cost is latched, its gate pattern is driven, and a done pulse is raised.

The filter step gains, the gain shift and the imbalance step are elaboration parameters. The switching weight is an input that the surrounding logic holds. For a weight of 0.1, that value is 0.1 expressed in cost units.

Top module: `mpc_nine_state_sel`

## Requirements
- R1: While reset is asserted and after it is released, `state_o` is 3 (the zero-level state with only the two bidirectional switches on), `gate_o` is 6'b110000 and `done_o` is 0.
- R2: `state_o` takes values 0..8 for states T1..T9. `gate_o[0]..gate_o[5]` drive S1..S6 with this table: 0:S1+S4, 1:S1+S6, 2:S4+S5, 3:S5+S6, 4:S2+S4, 5:S1+S3, 6:S3+S5, 7:S2+S6, 8:S2+S3. The level in half-DC-link units is +2 for 0, +1 for 1 and 2, 0 for 3..5, -1 for 6 and 7, and -2 for 8.
- R3: `done_o` is a one-cycle pulse. It rises on the ninth clock edge after the edge that samples an accepted `sample_stb`. `state_o` and `gate_o` change only on that edge.
- R4: The applied state is the candidate with the minimum cost. On equal cost, the lowest index wins.
- R5: Tracking term: `vdc = v_c1 + v_c2`, `vi = (level*vdc) >>> 1`, `ip = i_l + ((K_L*(vi - v_cf)) >>> SH)`, `vp = v_cf + ((K_C*(ip - i_o)) >>> SH)`, and the term is `|v_ref - vp|`. All shifts are arithmetic. Defaults are K_L=64, K_C=128, SH=8.
- R6: Switching penalty: `w_sw` times the number of toggles on S1..S4 between the applied state and the candidate. Toggles on S5 and S6 add nothing.
- R7: Imbalance term: `|(v_c1 - v_c2) + e*s*NB_STEP|`, with NB_STEP=16 by default. `e` is +1 for indices 1 and 7, -1 for indices 2 and 6, and 0 otherwise. `s` is -1 when `i_o` is negative and +1 otherwise.
- R8: The cost is the sum of the three terms, saturated to 24-bit unsigned. A large weight never wraps into a small cost.
- R9: A strobe that arrives while an evaluation is running is ignored. It produces no extra done pulse and does not change the outcome.
- R10: Inputs are used only as sampled at the accepted strobe. Changes during the evaluation have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_stb | input | 1 | One-cycle start of a control period |
| v_ref | input | 16 | Reference output voltage, signed |
| v_c1 | input | 16 | Upper DC-link capacitor voltage, signed |
| v_c2 | input | 16 | Lower DC-link capacitor voltage, signed |
| i_l | input | 16 | Filter inductor current, signed |
| v_cf | input | 16 | Filter capacitor voltage, signed |
| i_o | input | 16 | Load current, signed |
| w_sw | input | 24 | Switching weight in cost units, unsigned |
| gate_o | output | 6 | Gate vector, bit 0 = S1 ... bit 5 = S6 |
| state_o | output | 4 | Applied state index, 0..8 = T1..T9 |
| done_o | output | 1 | Pulse when a new state is applied |

## Verification
The assertions check on every cycle that the gate vector matches the applied index, and that the index stays in range. They also check that the applied state holds between done pulses, and that done appears exactly nine edges after an accepted strobe and at no other time. Whether the chosen state is the right one cannot be seen cycle by cycle. The bench scenarios show it by comparing the outcome against a model of the cost equations. Hand-worked cases cover four points: the redundant-state choice under both current signs, the tie break, weight saturation, and the exclusion of the bidirectional switches from the penalty. Ignored strobes and input changes during an evaluation are also shown only by scenarios.

// File: rtl/mpc_sel_pkg.sv
package mpc_sel_pkg;

  localparam int NUM_ST = 9;
  localparam int IDX_W  = 4;
  localparam int GATE_W = 6;

  // Gate pattern per state, bit 0 = S1
  function automatic logic [GATE_W-1:0] gate_of(input logic [IDX_W-1:0] idx);
    logic [GATE_W-1:0] g;
    case (idx)
      4'd0:    g = 6'b001001;
      4'd1:    g = 6'b100001;
      4'd2:    g = 6'b011000;
      4'd3:    g = 6'b110000;
      4'd4:    g = 6'b001010;
      4'd5:    g = 6'b000101;
      4'd6:    g = 6'b010100;
      4'd7:    g = 6'b100010;
      4'd8:    g = 6'b000110;
      default: g = 6'b110000;
    endcase
    return g;
  endfunction

  // Output level in half DC-link units
  function automatic logic signed [2:0] level_of(input logic [IDX_W-1:0] idx);
    logic signed [2:0] l;
    case (idx)
      4'd0:          l = 3'sd2;
      4'd1, 4'd2:    l = 3'sd1;
      4'd6, 4'd7:    l = -3'sd1;
      4'd8:          l = -3'sd2;
      default:       l = 3'sd0;
    endcase
    return l;
  endfunction

  // Effect on the upper capacitor for positive load current
  function automatic logic signed [1:0] np_effect(input logic [IDX_W-1:0] idx);
    logic signed [1:0] e;
    case (idx)
      4'd1, 4'd7: e = 2'sd1;
      4'd2, 4'd6: e = -2'sd1;
      default:    e = 2'sd0;
    endcase
    return e;
  endfunction

endpackage

// File: rtl/mpc_cand_cost.sv
module mpc_cand_cost
  import mpc_sel_pkg::*;
#(
  parameter int DW      = 16,
  parameter int WW      = 24,
  parameter int CW      = 24,
  parameter int K_L     = 64,
  parameter int K_C     = 128,
  parameter int SH      = 8,
  parameter int NB_STEP = 16
) (
  input  logic signed [DW-1:0] v_ref,
  input  logic signed [DW-1:0] v_c1,
  input  logic signed [DW-1:0] v_c2,
  input  logic signed [DW-1:0] i_l,
  input  logic signed [DW-1:0] v_cf,
  input  logic signed [DW-1:0] i_o,
  input  logic [WW-1:0]        w_sw,
  input  logic [IDX_W-1:0]     cand,
  input  logic [IDX_W-1:0]     prev,
  output logic [CW-1:0]        cost
);

  localparam int WIDE = 56;
  localparam logic signed [WIDE-1:0] KL_W = WIDE'(K_L);
  localparam logic signed [WIDE-1:0] KC_W = WIDE'(K_C);
  localparam logic signed [WIDE-1:0] NB_W = WIDE'(NB_STEP);
  localparam logic [GATE_W-1:0] OUTER_MASK = 6'b001111;

  function automatic logic [WIDE-1:0] mag(input logic signed [WIDE-1:0] x);
    return (x < 0) ? WIDE'(-x) : WIDE'(x);
  endfunction

  logic signed [WIDE-1:0] ref_w, c1_w, c2_w, il_w, cf_w, io_w;
  logic signed [WIDE-1:0] lvl_w, eff_w, sgn_w;
  logic signed [WIDE-1:0] vdc, vi, ip, vp, imb;
  logic [WIDE-1:0]        trk, pen, bal, sum;
  logic [2:0]             tog;

  always_comb begin
    ref_w = WIDE'(v_ref);
    c1_w  = WIDE'(v_c1);
    c2_w  = WIDE'(v_c2);
    il_w  = WIDE'(i_l);
    cf_w  = WIDE'(v_cf);
    io_w  = WIDE'(i_o);
    lvl_w = WIDE'(level_of(cand));
    eff_w = WIDE'(np_effect(cand));
    sgn_w = i_o[DW-1] ? -WIDE'(1) : WIDE'(1);

    // forward-Euler prediction of the filter state
    vdc = c1_w + c2_w;
    vi  = (lvl_w * vdc) >>> 1;
    ip  = il_w + ((KL_W * (vi - cf_w)) >>> SH);
    vp  = cf_w + ((KC_W * (ip - io_w)) >>> SH);
    trk = mag(ref_w - vp);

    // outer-switch transition penalty
    tog = 3'($countones((gate_of(prev) ^ gate_of(cand)) & OUTER_MASK));
    pen = WIDE'(tog) * WIDE'(w_sw);

    // neutral-point imbalance
    imb = (c1_w - c2_w) + eff_w * sgn_w * NB_W;
    bal = mag(imb);

    sum = trk + pen + bal;
    if (|sum[WIDE-1:CW]) cost = '1;
    else                 cost = sum[CW-1:0];
  end

endmodule

// File: rtl/mpc_argmin_seq.sv
module mpc_argmin_seq
  import mpc_sel_pkg::*;
#(
  parameter int CW = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CW-1:0]    cost,
  output logic [IDX_W-1:0] cand_o,
  output logic             busy_o,
  output logic             fin_valid_o,
  output logic [IDX_W-1:0] fin_idx_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ST - 1);

  logic             busy_q, busy_d;
  logic [IDX_W-1:0] cand_q, cand_d;
  logic [IDX_W-1:0] best_q, best_d;
  logic [CW-1:0]    bestc_q, bestc_d;
  logic             take, last;

  always_comb begin
    take    = (cand_q == '0) || (cost < bestc_q);
    last    = busy_q && (cand_q == LAST_IDX);
    busy_d  = busy_q;
    cand_d  = cand_q;
    best_d  = best_q;
    bestc_d = bestc_q;
    if (busy_q) begin
      if (take) begin
        best_d  = cand_q;
        bestc_d = cost;
      end
      if (last) busy_d = 1'b0;
      else      cand_d = cand_q + 1'b1;
    end else if (start) begin
      busy_d = 1'b1;
      cand_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cand_q  <= '0;
      best_q  <= '0;
      bestc_q <= '0;
    end else begin
      busy_q  <= busy_d;
      cand_q  <= cand_d;
      best_q  <= best_d;
      bestc_q <= bestc_d;
    end
  end

  assign cand_o      = cand_q;
  assign busy_o      = busy_q;
  assign fin_valid_o = last;
  assign fin_idx_o   = take ? cand_q : best_q;

endmodule

// File: rtl/mpc_nine_state_sel.sv
module mpc_nine_state_sel
  import mpc_sel_pkg::*;
#(
  parameter int DW      = 16,
  parameter int WW      = 24,
  parameter int CW      = 24,
  parameter int K_L     = 64,
  parameter int K_C     = 128,
  parameter int SH      = 8,
  parameter int NB_STEP = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample_stb,
  input  logic signed [DW-1:0] v_ref,
  input  logic signed [DW-1:0] v_c1,
  input  logic signed [DW-1:0] v_c2,
  input  logic signed [DW-1:0] i_l,
  input  logic signed [DW-1:0] v_cf,
  input  logic signed [DW-1:0] i_o,
  input  logic [WW-1:0]        w_sw,
  output logic [GATE_W-1:0]    gate_o,
  output logic [IDX_W-1:0]     state_o,
  output logic                 done_o
);

  localparam logic [IDX_W-1:0] ZERO_ST = IDX_W'(3);

  logic signed [DW-1:0] ref_q, c1_q, c2_q, il_q, cf_q, io_q;
  logic [WW-1:0]        w_q;
  logic [IDX_W-1:0]     state_q, state_d;
  logic                 done_q, done_d;
  logic                 accept, busy, fin_valid;
  logic [IDX_W-1:0]     cand, fin_idx;
  logic [CW-1:0]        cost;

  assign accept = sample_stb && !busy;

  // measurement snapshot, loaded only on an accepted strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= '0;
      c1_q  <= '0;
      c2_q  <= '0;
      il_q  <= '0;
      cf_q  <= '0;
      io_q  <= '0;
      w_q   <= '0;
    end else if (accept) begin
      ref_q <= v_ref;
      c1_q  <= v_c1;
      c2_q  <= v_c2;
      il_q  <= i_l;
      cf_q  <= v_cf;
      io_q  <= i_o;
      w_q   <= w_sw;
    end
  end

  mpc_cand_cost #(
    .DW(DW), .WW(WW), .CW(CW), .K_L(K_L), .K_C(K_C), .SH(SH), .NB_STEP(NB_STEP)
  ) u_cost (
    .v_ref(ref_q), .v_c1(c1_q), .v_c2(c2_q), .i_l(il_q), .v_cf(cf_q), .i_o(io_q),
    .w_sw(w_q), .cand(cand), .prev(state_q), .cost(cost)
  );

  mpc_argmin_seq #(.CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .cost(cost),
    .cand_o(cand), .busy_o(busy), .fin_valid_o(fin_valid), .fin_idx_o(fin_idx)
  );

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    if (fin_valid) begin
      state_d = fin_idx;
      done_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ZERO_ST;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign gate_o  = gate_of(state_q);
  assign state_o = state_q;
  assign done_o  = done_q;

endmodule

// File: rtl/mpc_sel_checker.sv
module mpc_sel_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       sample_stb,
  input logic [5:0] gate_o,
  input logic [3:0] state_o,
  input logic       done_o
);

  logic [3:0] cnt;
  logic [5:0] exp_gate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt <= '0;
    else if (cnt == 4'd9)             cnt <= '0;
    else if (cnt != 4'd0)             cnt <= cnt + 4'd1;
    else if (sample_stb)              cnt <= 4'd1;
  end

  always_comb begin
    unique case (state_o)
      4'd0: exp_gate = 6'b001001;
      4'd1: exp_gate = 6'b100001;
      4'd2: exp_gate = 6'b011000;
      4'd3: exp_gate = 6'b110000;
      4'd4: exp_gate = 6'b001010;
      4'd5: exp_gate = 6'b000101;
      4'd6: exp_gate = 6'b010100;
      4'd7: exp_gate = 6'b100010;
      4'd8: exp_gate = 6'b000110;
      default: exp_gate = 6'b000000;
    endcase
  end

  assert_gate_table_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o <= 4'd8) && (gate_o == exp_gate));

  assert_hold_between_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(state_o));

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 4'd9) |=> done_o);

  assert_no_stray_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != 4'd9) |=> !done_o);

endmodule

bind mpc_nine_state_sel mpc_sel_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb),
  .gate_o(gate_o), .state_o(state_o), .done_o(done_o)
);

// File: tb/tb_mpc_nine_state_sel.sv
module tb_mpc_nine_state_sel;

  typedef struct packed {
    logic signed [15:0] vref;
    logic signed [15:0] vc1;
    logic signed [15:0] vc2;
    logic signed [15:0] il;
    logic signed [15:0] vcf;
    logic signed [15:0] io;
    logic [23:0]        w;
    logic signed [7:0]  hexp;   // hand-worked expected index, -1 = model only
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{16'sd75,    16'sd1100,  16'sd900,   16'sd0,     16'sd0,     16'sd100,   24'd0,   8'sd2},
    '{16'sd175,   16'sd1100,  16'sd900,   16'sd0,     16'sd0,     -16'sd100,  24'd0,   8'sd1},
    '{16'sd200,   16'sd1000,  16'sd1000,  16'sd0,     16'sd0,     16'sd0,     24'd0,   -8'sd1},
    '{-16'sd300,  16'sd1000,  16'sd1000,  16'sd0,     16'sd0,     16'sd0,     24'd0,   -8'sd1},
    '{-16'sd150,  16'sd900,   16'sd1100,  16'sd50,    -16'sd20,   -16'sd60,   24'd30,  -8'sd1},
    '{16'sd0,     16'sd1000,  16'sd1000,  16'sd10,    16'sd5,     16'sd0,     24'd40,  -8'sd1},
    '{16'sd3000,  16'sd15000, 16'sd14000, -16'sd2000, 16'sd1000,  16'sd500,   24'd0,   -8'sd1},
    '{-16'sd3000, 16'sd14000, 16'sd15000, 16'sd2000,  -16'sd1000, -16'sd500,  24'd100, -8'sd1},
    '{16'sd32767, 16'sd32767, 16'sd32767, -16'sd32768,-16'sd32768,16'sd32767, 24'd0,   -8'sd1},
    '{-16'sd32768,-16'sd32768,-16'sd32768,16'sd32767, 16'sd32767, -16'sd32768,24'd5,   -8'sd1},
    '{16'sd120,   16'sd1200,  16'sd800,   16'sd300,   16'sd100,   16'sd200,   24'd200, -8'sd1},
    '{-16'sd60,   16'sd800,   16'sd1200,  -16'sd300,  -16'sd100,  -16'sd200,  24'd2,   -8'sd1}
  };

  localparam longint KL = 64, KC = 128, SHV = 8, NB = 16;
  localparam longint CMAX = (64'd1 << 24) - 1;

  logic clk, rst_n, sample_stb;
  logic signed [15:0] v_ref, v_c1, v_c2, i_l, v_cf, i_o;
  logic [23:0] w_sw;
  logic [5:0]  gate_o;
  logic [3:0]  state_o;
  logic        done_o;

  int checks = 0;
  int errors = 0;

  mpc_nine_state_sel dut (
    .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb),
    .v_ref(v_ref), .v_c1(v_c1), .v_c2(v_c2), .i_l(i_l), .v_cf(v_cf), .i_o(i_o),
    .w_sw(w_sw), .gate_o(gate_o), .state_o(state_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [5:0] tgate(input int s);
    case (s)
      0: return 6'b001001;  1: return 6'b100001;  2: return 6'b011000;
      3: return 6'b110000;  4: return 6'b001010;  5: return 6'b000101;
      6: return 6'b010100;  7: return 6'b100010;  default: return 6'b000110;
    endcase
  endfunction

  function automatic longint tlevel(input int s);
    case (s)
      0: return 2;  1, 2: return 1;  6, 7: return -1;  8: return -2;  default: return 0;
    endcase
  endfunction

  function automatic longint teff(input int s);
    if (s == 1 || s == 7) return 1;
    if (s == 2 || s == 6) return -1;
    return 0;
  endfunction

  function automatic longint labs(input longint x);
    return (x < 0) ? -x : x;
  endfunction

  // cost model from R4..R8
  function automatic int model(input vec_t v, input int prev);
    longint vdc, vi, ip, vp, trk, pen, bal, sum, best;
    int bi, tog;
    best = 0; bi = 0;
    vdc = longint'(v.vc1) + longint'(v.vc2);
    for (int c = 0; c < 9; c++) begin
      vi  = (tlevel(c) * vdc) >>> 1;
      ip  = longint'(v.il) + ((KL * (vi - longint'(v.vcf))) >>> SHV);
      vp  = longint'(v.vcf) + ((KC * (ip - longint'(v.io))) >>> SHV);
      trk = labs(longint'(v.vref) - vp);
      tog = $countones((tgate(prev) ^ tgate(c)) & 6'b001111);
      pen = longint'(tog) * longint'(v.w);
      bal = labs(longint'(v.vc1) - longint'(v.vc2) + teff(c) * ((v.io < 0) ? -1 : 1) * NB);
      sum = trk + pen + bal;
      if (sum > CMAX) sum = CMAX;
      if (c == 0 || sum < best) begin best = sum; bi = c; end
    end
    return bi;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic put(input vec_t v);
    v_ref = v.vref; v_c1 = v.vc1; v_c2 = v.vc2;
    i_l = v.il; v_cf = v.vcf; i_o = v.io; w_sw = v.w;
  endtask

  // strobe once at a negedge, then count negedges until done
  task automatic run_eval(input vec_t v, output int lat);
    @(negedge clk);
    put(v);
    sample_stb = 1'b1;
    lat = 0;
    for (int n = 0; n < 30; n++) begin
      @(negedge clk);
      sample_stb = 1'b0;
      lat++;
      if (done_o) break;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    sample_stb = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lat, prev, e;
    vec_t v;
    rst_n = 1'b0;
    sample_stb = 1'b0;
    put(VEC[0]);
    repeat (2) @(negedge clk);
    // R1: state during reset
    check(state_o == 4'd3, "R1 state in reset", int'(state_o), 3);
    check(gate_o == 6'b110000, "R1 gates in reset", int'(gate_o), 'h30);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(state_o == 4'd3 && done_o == 1'b0, "R1 after release", int'(state_o), 3);

    // vector walk: R5, R6, R7, R2, R3
    prev = 3;
    for (int k = 0; k < NV; k++) begin
      v = VEC[k];
      e = model(v, prev);
      run_eval(v, lat);
      check(lat == 10, "R3 latency", lat, 10);
      check(int'(state_o) == e, "R4 R5 R7 chosen state", int'(state_o), e);
      check(gate_o == tgate(e), "R2 gate pattern", int'(gate_o), int'(tgate(e)));
      if (v.hexp >= 0)
        check(int'(state_o) == int'(v.hexp), "R7 redundant choice", int'(state_o), int'(v.hexp));
      @(negedge clk);
      check(done_o == 1'b0, "R3 done one cycle", int'(done_o), 0);
      prev = e;
    end

    // R4: all costs zero -> lowest index
    v = '{16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 24'd0, -8'sd1};
    run_eval(v, lat);
    check(state_o == 4'd0, "R4 tie to lowest", int'(state_o), 0);

    // R6: only S1..S4 toggles count (from T4, weight 100 -> T3)
    do_reset();
    v = VEC[0]; v.w = 24'd100;
    run_eval(v, lat);
    check(state_o == 4'd2, "R6 outer switches only", int'(state_o), 2);
    // R6: heavy weight keeps the applied zero state
    do_reset();
    v = VEC[0]; v.w = 24'd1000;
    run_eval(v, lat);
    check(state_o == 4'd3, "R6 weight holds state", int'(state_o), 3);

    // R8: penalty saturates instead of wrapping
    do_reset();
    v = VEC[0]; v.vref = 16'sd200; v.w = 24'h800001;
    run_eval(v, lat);
    check(state_o == 4'd3, "R8 saturation", int'(state_o), 3);

    // R9: second strobe during evaluation ignored
    do_reset();
    @(negedge clk);
    put(VEC[0]);
    sample_stb = 1'b1;
    @(negedge clk);
    sample_stb = 1'b0;
    repeat (2) @(negedge clk);
    put(VEC[1]);
    sample_stb = 1'b1;
    @(negedge clk);
    sample_stb = 1'b0;
    begin
      int dones = 0;
      for (int n = 0; n < 25; n++) begin
        @(negedge clk);
        if (done_o) dones++;
      end
      check(dones == 1, "R9 single done", dones, 1);
    end
    check(state_o == 4'd2, "R9 outcome of first strobe", int'(state_o), 2);

    // R10: input changes during evaluation have no effect
    do_reset();
    @(negedge clk);
    put(VEC[1]);
    sample_stb = 1'b1;
    @(negedge clk);
    sample_stb = 1'b0;
    put(VEC[0]);
    repeat (12) @(negedge clk);
    check(state_o == 4'd1, "R10 sampled inputs", int'(state_o), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule